// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block counts ticks on a 16-bit up-counter and signals when the count crosses a programmable boundary. It has two count-enable sources, a fast system tick and a slow auxiliary tick. Both are single-cycle enable pulses in the block's own clock domain. A small control register chooses which source advances the counter, and how many ticks make up one timeout: 32768, 8192, 512 or 64.

In watchdog mode, an expiry produces a one-cycle reset request for the rest of the chip. The same expiry puts the control register back to its power-up values. Software prevents the expiry by writing the counter-clear bit before the timeout runs out. In interval mode, an expiry sets an interrupt flag instead, and the counter keeps running, so the flag comes back once per timeout. The flag stays set until software clears it or until the interrupt controller pulses the acknowledge input.

After reset the block is already armed: it is in watchdog mode, counting the fast tick, with the longest timeout.

Top module: `guard_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 (watchdog mode, fast source, timeout code 0, hold off), `reset_req` is 0 and `irq` is 0.
- R2: The timeout code in bits [3:2] selects the number of source ticks counted from a cleared counter to expiry: 0 gives 32768 ticks, 1 gives 8192, 2 gives 512 and 3 gives 64. Expiry is the tick that carries into counter bit 15, 13, 9 or 6 respectively.
- R3: Bit 1 selects the tick source: 0 selects `fast_tick`, 1 selects `slow_tick`. Pulses on the source that is not selected neither advance the counter nor cause an expiry.
- R4: In watchdog mode (bit 0 = 0), an expiry drives `reset_req` high for exactly the one clock after the expiring tick. On that same edge, the control register returns to the R1 values and the counter returns to zero.
- R5: In interval mode (bit 0 = 1), an expiry sets `irq` on the expiring tick's edge and never raises `reset_req`. The counter keeps running, so `irq` is set again after every further full timeout.
- R6: `irq` stays set until `irq_ack` is pulsed or a write has bit 6 = 1. If an expiry and a clear happen in the same cycle, the expiry wins and `irq` stays set.
- R7: A write with bit 5 = 1 zeroes the counter on that clock edge, and a tick in the same cycle is dropped. Bit 5 always reads back as 0. After a clear, a full timeout must elapse before the next expiry.
- R8: While hold (bit 4) is 1, the counter does not move and no expiry occurs. When hold is released, counting resumes from the held value.
- R9: A write that changes the source or the timeout code does not clear the counter. The new setting applies from the next tick on.
- R10: `cfg_rdata` reads {irq, 0, hold, timeout code, source, mode} in bits 6 down to 0. A write takes mode, source, timeout code and hold from the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | Fast system count-enable pulse |
| slow_tick | input | 1 | Slow auxiliary count-enable pulse |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write data |
| cfg_rdata | output | 7 | Control register and flag read value |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| reset_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interval interrupt flag |

## Verification
Every cycle, the assertions check these relations: the counter steps by exactly one per accepted tick, it stays still while held, and it reads zero after a clear. They also check that the reset request is a single-cycle pulse that comes only from watchdog mode, that the interrupt flag is set on an interval expiry and holds until it is cleared, and that the control register is restored after a watchdog expiry.

The bench scenarios are the only place where the tick counts themselves are checked. They cover every timeout code on both sources, the periodic repetition in interval mode, service by clearing, resuming after a hold, and the point where a timeout change made mid-count lands. They also check that the unselected source has no effect and that an expiry takes priority over an acknowledge in the same cycle.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  localparam int CFG_W = 7;

  // control word bit positions
  localparam int B_MODE   = 0;
  localparam int B_SRC    = 1;
  localparam int B_TAP_LO = 2;
  localparam int B_TAP_HI = 3;
  localparam int B_HOLD   = 4;
  localparam int B_CLR    = 5;
  localparam int B_FLAG   = 6;

  typedef struct packed {
    logic       hold;
    logic [1:0] tap;
    logic       src;
    logic       itv;   // 1 = interval mode, 0 = watchdog mode
  } gt_cfg_t;

  localparam gt_cfg_t CFG_RST = '{hold: 1'b0, tap: 2'd0, src: 1'b0, itv: 1'b0};

endpackage

// File: rtl/gt_rst_sync.sv
module gt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/gt_ctrl_reg.sv
module gt_ctrl_reg
  import guard_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             wd_fire_i,
  output gt_cfg_t          cfg_o,
  output logic             clr_o,
  output logic             flag_clr_o
);

  gt_cfg_t cfg_q;
  gt_cfg_t cfg_d;
  logic    cfg_en;

  // a watchdog expiry overrides a write in the same cycle
  assign cfg_en = wd_fire_i | we_i;

  always_comb begin
    cfg_d = cfg_q;
    if (wd_fire_i) begin
      cfg_d = CFG_RST;
    end else if (we_i) begin
      cfg_d.itv  = wdata_i[B_MODE];
      cfg_d.src  = wdata_i[B_SRC];
      cfg_d.tap  = wdata_i[B_TAP_HI:B_TAP_LO];
      cfg_d.hold = wdata_i[B_HOLD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_o      = cfg_q;
  assign clr_o      = we_i & wdata_i[B_CLR];
  assign flag_clr_o = we_i & wdata_i[B_FLAG];

  // R4: watchdog expiry restores the power-up configuration
  a_r4_cfg_restore: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire_i |=> (cfg_q == CFG_RST));

  // R10: without a write or an expiry the configuration is unchanged
  a_r10_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !wd_fire_i) |=> $stable(cfg_q));

endmodule

// File: rtl/gt_counter.sv
module gt_counter
  import guard_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAP_C0 = 15,
  parameter int TAP_C1 = 13,
  parameter int TAP_C2 = 9,
  parameter int TAP_C3 = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fast_tick_i,
  input  logic    slow_tick_i,
  input  gt_cfg_t cfg_i,
  input  logic    clr_i,
  input  logic    wd_fire_i,
  output logic    expire_o
);

  localparam int N_TAPS = 4;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic              cnt_en;
  logic              tick_sel;
  logic              tick_act;
  logic [N_TAPS-1:0] tap_full;

  // one full-low-bits detector per timeout code
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int POS = (g == 0) ? TAP_C0 :
                         (g == 1) ? TAP_C1 :
                         (g == 2) ? TAP_C2 : TAP_C3;
    assign tap_full[g] = &cnt_q[POS-1:0];
  end

  assign tick_sel = cfg_i.src ? slow_tick_i : fast_tick_i;
  assign tick_act = tick_sel & ~cfg_i.hold;

  // the tick that carries into the selected bit is the expiry
  assign expire_o = tick_act & ~clr_i & tap_full[cfg_i.tap];

  assign cnt_en = clr_i | wd_fire_i | tick_act;

  always_comb begin
    if (clr_i || wd_fire_i) cnt_d = '0;
    else                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: a clear leaves the counter at zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R8: hold freezes the counter
  a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.hold && !clr_i && !wd_fire_i) |=> $stable(cnt_q));

  // R2: each accepted tick advances the count by one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_act && !clr_i && !wd_fire_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3: a pulse only on the unselected source leaves the counter alone
  a_r3_other_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !wd_fire_i &&
     ((cfg_i.src && fast_tick_i && !slow_tick_i) ||
      (!cfg_i.src && slow_tick_i && !fast_tick_i))) |=> $stable(cnt_q));

endmodule

// File: rtl/gt_event.sv
module gt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic itv_i,
  input  logic flag_clr_i,
  input  logic ack_i,
  output logic wd_fire_o,
  output logic reset_req_o,
  output logic irq_o
);

  logic rreq_q;
  logic rreq_d;
  logic irq_q;
  logic irq_d;
  logic itv_fire;

  assign wd_fire_o = expire_i & ~itv_i;
  assign itv_fire  = expire_i & itv_i;

  always_comb begin
    rreq_d = wd_fire_o;
    irq_d  = irq_q;
    if (itv_fire)                 irq_d = 1'b1;
    else if (flag_clr_i || ack_i) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rreq_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      rreq_q <= rreq_d;
      irq_q  <= irq_d;
    end
  end

  assign reset_req_o = rreq_q;
  assign irq_o       = irq_q;

  // R4: the reset request lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o);

  // R5: no reset request comes out of interval mode
  a_r5_no_reset_itv: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> !$past(itv_i));

  // R5: an interval expiry sets the flag
  a_r5_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && itv_i) |=> irq_o);

  // R6: the flag holds until it is cleared
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !flag_clr_i && !ack_i) |=> irq_o);

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAP_C0 = 15,
  parameter int TAP_C1 = 13,
  parameter int TAP_C2 = 9,
  parameter int TAP_C3 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             irq_ack,
  output logic             reset_req,
  output logic             irq
);

  logic    rst_n_int;
  gt_cfg_t cfg;
  logic    clr;
  logic    flag_clr;
  logic    expire;
  logic    wd_fire;

  gt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gt_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .we_i       (cfg_we),
    .wdata_i    (cfg_wdata),
    .wd_fire_i  (wd_fire),
    .cfg_o      (cfg),
    .clr_o      (clr),
    .flag_clr_o (flag_clr)
  );

  gt_counter #(
    .CNT_W  (CNT_W),
    .TAP_C0 (TAP_C0),
    .TAP_C1 (TAP_C1),
    .TAP_C2 (TAP_C2),
    .TAP_C3 (TAP_C3)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .fast_tick_i (fast_tick),
    .slow_tick_i (slow_tick),
    .cfg_i       (cfg),
    .clr_i       (clr),
    .wd_fire_i   (wd_fire),
    .expire_o    (expire)
  );

  gt_event u_evt (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .expire_i    (expire),
    .itv_i       (cfg.itv),
    .flag_clr_i  (flag_clr),
    .ack_i       (irq_ack),
    .wd_fire_o   (wd_fire),
    .reset_req_o (reset_req),
    .irq_o       (irq)
  );

  always_comb begin
    cfg_rdata                    = '0;
    cfg_rdata[B_MODE]            = cfg.itv;
    cfg_rdata[B_SRC]             = cfg.src;
    cfg_rdata[B_TAP_HI:B_TAP_LO] = cfg.tap;
    cfg_rdata[B_HOLD]            = cfg.hold;
    cfg_rdata[B_FLAG]            = irq;
  end

endmodule

// File: tb/guard_timer_tb_top.sv
module guard_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic       clk;
  logic       rst_n;
  logic       fast_tick;
  logic       slow_tick;
  logic       cfg_we;
  logic [6:0] cfg_wdata;
  logic [6:0] cfg_rdata;
  logic       irq_ack;
  logic       reset_req;
  logic       irq;

  int n_chk;
  int n_bad;
  int cyc;
  bit done;

  guard_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_ack   (irq_ack),
    .reset_req (reset_req),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] mk(bit itv, bit src, int tap, bit hold, bit clr, bit fclr);
    logic [6:0] w;
    w = '0;
    w[0] = itv; w[1] = src; w[3:2] = tap[1:0]; w[4] = hold; w[5] = clr; w[6] = fclr;
    return w;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  // one clock with the given stimulus; inputs change and results are read 1 unit after the edge
  task automatic step(bit f, bit s, bit a);
    fast_tick = f; slow_tick = s; irq_ack = a;
    @(posedge clk); #1;
    fast_tick = 1'b0; slow_tick = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic wr(logic [6:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // n selected ticks; optionally the other source pulses at the same time
  task automatic ticks(int n, bit slow, bit other);
    for (int i = 0; i < n; i++) begin
      if (slow) step(other, 1'b1, 1'b0);
      else      step(1'b1, other, 1'b0);
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_LIMIT && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    fast_tick = 0; slow_tick = 0; irq_ack = 0; cfg_we = 0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step(0, 0, 0);

    // R1 power-up state
    check("R1 rdata", cfg_rdata, 0);
    check("R1 reset_req", reset_req, 0);
    check("R1 irq", irq, 0);

    // R2/R4 default watchdog timeout of 32768 fast ticks
    ticks(32767, 0, 0);
    check("R2 default no early reset", reset_req, 0);
    ticks(1, 0, 0);
    check("R2 default expiry at 32768", reset_req, 1);
    step(0, 0, 0);
    check("R4 pulse one cycle", reset_req, 0);

    // R4 restore of configuration after watchdog expiry
    wr(mk(0, 0, 3, 0, 1, 0));
    check("R10 readback wd tap3", cfg_rdata, 7'h0C);
    ticks(63, 0, 0);
    check("R4 no reset before 64", reset_req, 0);
    ticks(1, 0, 0);
    check("R4 reset at 64", reset_req, 1);
    check("R4 cfg restored", cfg_rdata, 0);
    ticks(64, 0, 0);
    check("R4 restored timeout longer", reset_req, 0);

    // R7 service by clearing
    wr(mk(0, 0, 3, 0, 1, 0));
    ticks(60, 0, 0);
    wr(mk(0, 0, 3, 0, 1, 0));
    check("R7 clear bit reads 0", cfg_rdata[5], 0);
    ticks(63, 0, 0);
    check("R7 serviced no reset", reset_req, 0);
    ticks(1, 0, 0);
    check("R7 full period after clear", reset_req, 1);
    step(0, 0, 0);

    // R2/R3/R5/R6 interval sweep over both sources and the short timeout codes
    for (int src = 0; src < 2; src++) begin
      for (int tap = 1; tap < 4; tap++) begin
        int n;
        n = (tap == 1) ? 8192 : (tap == 2) ? 512 : 64;
        wr(mk(1, src[0], tap, 0, 1, 1));
        ticks(n - 1, src[0], 1);
        check("R2 interval not yet expired", irq, 0);
        for (int k = 0; k < 50; k++) step(src[0] ? 1'b1 : 1'b0, src[0] ? 1'b0 : 1'b1, 1'b0);
        check("R3 other source ignored", irq, 0);
        ticks(1, src[0], 1);
        check("R2 interval expiry", irq, 1);
        check("R5 no reset in interval mode", reset_req, 0);
        step(0, 0, 1);
        check("R6 ack clears flag", irq, 0);
        ticks(n - 1, src[0], 0);
        check("R5 periodic not yet", irq, 0);
        ticks(1, src[0], 0);
        check("R5 periodic repeat", irq, 1);
        wr(mk(1, src[0], tap, 0, 0, 1));
        check("R6 software clear", irq, 0);
      end
    end

    // R8 hold
    wr(mk(1, 0, 3, 0, 1, 1));
    ticks(63, 0, 0);
    wr(mk(1, 0, 3, 1, 0, 0));
    ticks(200, 0, 0);
    check("R8 held no expiry", irq, 0);
    wr(mk(1, 0, 3, 0, 0, 0));
    ticks(1, 0, 0);
    check("R8 resume from held value", irq, 1);

    // R9 timeout change without clearing
    begin
      int pre;
      int rem;
      pre = 100;
      rem = 64 - (pre % 64);
      wr(mk(1, 0, 2, 0, 1, 1));
      ticks(pre, 0, 0);
      wr(mk(1, 0, 3, 0, 0, 0));
      ticks(rem - 1, 0, 0);
      check("R9 not yet", irq, 0);
      ticks(1, 0, 0);
      check("R9 new code from running count", irq, 1);
    end

    // R6 expiry wins over acknowledge in the same cycle
    wr(mk(1, 0, 3, 0, 1, 1));
    ticks(63, 0, 0);
    step(1, 0, 1);
    check("R6 set beats ack", irq, 1);

    // R10 field positions
    wr(7'h7B);
    check("R10 readback fields", cfg_rdata, 7'h1B);
    wr(mk(1, 0, 0, 0, 1, 1));
    check("R10 readback itv only", cfg_rdata, 7'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule